// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers level-sensitive interrupt lines from a configurable number of peripherals, together with a small group of request bits that software sets and clears through registers. Every source carries its own 4-bit priority. Each cycle, a comparison tree finds the most urgent pending source. When that source's priority is strictly above a software-writable mask, the block raises one registered request line to the processor. Alongside the request it drives the winning source number and a handler address. The handler address is a base value plus sixteen bytes per source number.

Software takes a request by writing the acknowledge register. That write saves the running mask in a 16-deep last-in-first-out store and raises the mask to the priority of the source being served, so only more urgent sources can preempt the handler. An end-of-interrupt write restores the saved mask. Software may also raise the mask by hand to hold off preemption while it owns a shared resource. A handler can pass the rest of its work to a less urgent handler by setting a software request bit.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, the request output is low and the index and address outputs are zero. The mask, every priority, every software request bit and the vector base all read zero, and the mask store is empty.
- R2: The priority of source s is read and written at word address 0x100+s. Only write-data bits [3:0] are kept, and the field reads back in bits [3:0].
- R3: A source whose priority is 0 never causes a request, even while its line or bit is set.
- R4: The request rises one cycle after the highest pending priority becomes strictly greater than the mask. An equal priority raises nothing. The mask is read and written at address 0x000, bits [3:0].
- R5: Sources 0 to N_SOFT-1 are the software bits and the peripheral lines follow in order. The higher priority wins, and among equal priorities the lower source number wins.
- R6: The vector address equals the base plus 16 times the vector index. The base is written at address 0x001, and its bits [3:0] are forced to zero.
- R7: Writing ones to address 0x004 sets software bits, and writing ones to address 0x005 clears them. Address 0x004 reads the bits back, and a set bit arbitrates like a peripheral line.
- R8: While a request is up and its source stays pending above the mask, the index holds. A more urgent arrival does not change it.
- R9: If the presented source stops being pending, or the mask rises to its level or above, the request and index are re-evaluated on the next clock: they either drop or move to the current winner.
- R10: A write to address 0x002 while the request is up takes that request. The request drops on the next clock, the old mask is saved and the mask becomes the served source's priority. Reading address 0x002 returns the index. A write with no request up changes nothing.
- R11: A write to address 0x003 restores the most recently saved mask, in last-in-first-out order.
- R12: The store holds 16 masks. An acknowledge with the store full changes nothing, and an end-of-interrupt write with the store empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | N_PERIPH | Peripheral request lines, level sensitive |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| irq_req | output | 1 | Request to the processor |
| vec_idx | output | IDX_W | Number of the presented source |
| vec_addr | output | VA_W | Handler address of the presented source |

## Verification
The properties assume that `irq_src` levels are synchronous to `clk` and that the register port carries at most one access per cycle. Because of that, a mask write can never coincide with an acknowledge or an end-of-interrupt write. The bench drives every input on the falling edge and holds each peripheral line steady until it deliberately drops it. It stages multi-source cases behind a mask of 15, so that all candidates become visible to arbitration on the same clock.

// File: rtl/pvi_pkg.sv
package pvi_pkg;
  localparam int PRI_W = 4;
  typedef logic [PRI_W-1:0] pri_t;

  // word addresses of the register port
  localparam int REG_MASK  = 0;
  localparam int REG_VBASE = 1;
  localparam int REG_ACK   = 2;
  localparam int REG_EOI   = 3;
  localparam int REG_SWSET = 4;
  localparam int REG_SWCLR = 5;
  localparam int REG_PRI0  = 256;

  function automatic int clog2_min1(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pvi_arbiter.sv
// Balanced comparison tree: highest priority wins, the left (lower number) side wins ties.
// Priority 0 doubles as "nothing pending".
module pvi_arbiter
  import pvi_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = 3
) (
  input  pri_t             cand_pri [NSRC],
  output logic [IDX_W-1:0] win_idx,
  output pri_t             win_pri
);
  localparam int LVLS = (NSRC > 1) ? $clog2(NSRC) : 0;
  localparam int SIZE = 1 << LVLS;

  // heap layout: node k has children 2k and 2k+1, leaves at SIZE..2*SIZE-1
  pri_t             t_pri [1:2*SIZE-1];
  logic [IDX_W-1:0] t_idx [1:2*SIZE-1];

  generate
    for (genvar i = 0; i < SIZE; i++) begin : g_leaf
      if (i < NSRC) begin : g_real
        assign t_pri[SIZE+i] = cand_pri[i];
        assign t_idx[SIZE+i] = IDX_W'(i);
      end else begin : g_pad
        assign t_pri[SIZE+i] = '0;
        assign t_idx[SIZE+i] = '0;
      end
    end
    for (genvar k = 1; k < SIZE; k++) begin : g_node
      logic left_wins;
      assign left_wins = (t_pri[2*k] >= t_pri[2*k+1]);
      assign t_pri[k]  = left_wins ? t_pri[2*k] : t_pri[2*k+1];
      assign t_idx[k]  = left_wins ? t_idx[2*k] : t_idx[2*k+1];
    end
  endgenerate

  assign win_pri = t_pri[1];
  assign win_idx = t_idx[1];
endmodule

// File: rtl/pvi_pri_stack.sv
// LIFO of saved mask values; push when full and pop when empty are ignored.
module pvi_pri_stack
  import pvi_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  pri_t din,
  output pri_t top,
  output logic full,
  output logic empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  pri_t             slot [DEPTH];
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty && !push;

  always_comb begin
    cnt_d = cnt_q;
    if (do_push)     cnt_d = cnt_q + CNT_W'(1);
    else if (do_pop) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      pri_t slot_q;
      logic slot_we;
      assign slot_we = do_push && (cnt_q == CNT_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       slot_q <= '0;
        else if (slot_we) slot_q <= din;
      end
      assign slot[e] = slot_q;
    end
  endgenerate

  always_comb begin
    top = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (cnt_q == CNT_W'(e + 1)) top = slot[e];
    end
  end
endmodule

// File: rtl/pvi_vec_stage.sv
// Registered request and index; holds the presented source until it is taken or lost.
module pvi_vec_stage
  import pvi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int VA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  win_idx,
  input  pri_t              win_pri,
  input  pri_t              mask,
  input  logic              held_live,
  input  logic              ack_take,
  input  logic [VA_W-5:0]   vbase,
  output logic              irq_req,
  output logic [IDX_W-1:0]  vec_idx,
  output logic [VA_W-1:0]   vec_addr
);
  logic             req_q, req_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    req_d = req_q;
    idx_d = idx_q;
    if (ack_take) begin
      req_d = 1'b0;
    end else if (req_q && held_live) begin
      req_d = 1'b1;
    end else if (win_pri > mask) begin
      req_d = 1'b1;
      idx_d = win_idx;
    end else begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      idx_q <= '0;
    end else begin
      req_q <= req_d;
      idx_q <= idx_d;
    end
  end

  assign irq_req  = req_q;
  assign vec_idx  = idx_q;
  assign vec_addr = {vbase + (VA_W-4)'(idx_q), 4'b0000};
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvi_pkg::*;
#(
  parameter int N_PERIPH    = 298,
  parameter int N_SOFT      = 8,
  parameter int STACK_DEPTH = 16,
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int VA_W        = 32,
  localparam int NSRC       = N_SOFT + N_PERIPH,
  localparam int IDX_W      = clog2_min1(NSRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PERIPH-1:0] irq_src,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_req,
  output logic [IDX_W-1:0]    vec_idx,
  output logic [VA_W-1:0]     vec_addr
);
  // ---------------- register decode ----------------
  logic mask_we, vbase_we, ack_wr, eoi_wr, swset_we, swclr_we;
  assign mask_we  = reg_we && (reg_addr == ADDR_W'(REG_MASK));
  assign vbase_we = reg_we && (reg_addr == ADDR_W'(REG_VBASE));
  assign ack_wr   = reg_we && (reg_addr == ADDR_W'(REG_ACK));
  assign eoi_wr   = reg_we && (reg_addr == ADDR_W'(REG_EOI));
  assign swset_we = reg_we && (reg_addr == ADDR_W'(REG_SWSET));
  assign swclr_we = reg_we && (reg_addr == ADDR_W'(REG_SWCLR));

  // ---------------- per-source priority ----------------
  pri_t pri_q [NSRC];
  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_pri
      pri_t q;
      logic we;
      assign we = reg_we && (reg_addr == ADDR_W'(REG_PRI0 + s));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= reg_wdata[PRI_W-1:0];
      end
      assign pri_q[s] = q;
    end
  endgenerate

  // ---------------- software request bits ----------------
  logic [N_SOFT-1:0] sw_q, sw_d;
  always_comb begin
    sw_d = sw_q;
    if (swset_we) sw_d = sw_d | reg_wdata[N_SOFT-1:0];
    if (swclr_we) sw_d = sw_d & ~reg_wdata[N_SOFT-1:0];
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= '0;
    else        sw_q <= sw_d;
  end

  // ---------------- vector base ----------------
  logic [VA_W-5:0] vbase_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vbase_q <= '0;
    else if (vbase_we) vbase_q <= reg_wdata[VA_W-1:4];
  end

  // ---------------- arbitration ----------------
  logic [NSRC-1:0]  raw;
  pri_t             cand [NSRC];
  logic [IDX_W-1:0] win_idx;
  pri_t             win_pri;

  assign raw = {irq_src, sw_q};
  always_comb begin
    for (int s = 0; s < NSRC; s++) cand[s] = raw[s] ? pri_q[s] : '0;
  end

  pvi_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .cand_pri (cand),
    .win_idx  (win_idx),
    .win_pri  (win_pri)
  );

  // ---------------- mask and saved-mask store ----------------
  pri_t mask_q, mask_d;
  pri_t held_pri, stk_top;
  logic held_live, ack_take, eoi_take, stk_full, stk_empty;

  assign held_pri  = pri_q[vec_idx];
  assign held_live = raw[vec_idx] && (held_pri > mask_q);
  assign ack_take  = ack_wr && irq_req && !stk_full;
  assign eoi_take  = eoi_wr && !stk_empty;

  pvi_pri_stack #(.DEPTH(STACK_DEPTH)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ack_take),
    .pop   (eoi_take),
    .din   (mask_q),
    .top   (stk_top),
    .full  (stk_full),
    .empty (stk_empty)
  );

  always_comb begin
    mask_d = mask_q;
    if (mask_we)       mask_d = reg_wdata[PRI_W-1:0];
    else if (ack_take) mask_d = held_pri;
    else if (eoi_take) mask_d = stk_top;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  // ---------------- request / vector output ----------------
  pvi_vec_stage #(.IDX_W(IDX_W), .VA_W(VA_W)) u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_idx   (win_idx),
    .win_pri   (win_pri),
    .mask      (mask_q),
    .held_live (held_live),
    .ack_take  (ack_take),
    .vbase     (vbase_q),
    .irq_req   (irq_req),
    .vec_idx   (vec_idx),
    .vec_addr  (vec_addr)
  );

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(REG_MASK))       reg_rdata = DATA_W'(mask_q);
    else if (reg_addr == ADDR_W'(REG_VBASE)) reg_rdata = DATA_W'({vbase_q, 4'b0000});
    else if (reg_addr == ADDR_W'(REG_ACK))   reg_rdata = DATA_W'(vec_idx);
    else if (reg_addr == ADDR_W'(REG_SWSET)) reg_rdata = DATA_W'(sw_q);
    else if (reg_addr == ADDR_W'(REG_SWCLR)) reg_rdata = DATA_W'(sw_q);
    else begin
      for (int s = 0; s < NSRC; s++) begin
        if (reg_addr == ADDR_W'(REG_PRI0 + s)) reg_rdata = DATA_W'(pri_q[s]);
      end
    end
  end
endmodule

// File: rtl/pvi_checker.sv
module pvi_checker
  import pvi_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic [IDX_W-1:0] vec_idx,
  input logic             held_live,
  input logic             ack_wr,
  input logic             eoi_wr,
  input logic             ack_take,
  input logic             eoi_take,
  input logic             stk_full,
  input logic             stk_empty,
  input pri_t             held_pri,
  input pri_t             stk_top,
  input pri_t             mask_q,
  input pri_t             win_pri
);
  AST_RISE_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($past(win_pri) > $past(mask_q))); // R4

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (32'(vec_idx) < NSRC)); // R5

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && held_live && !ack_take) |=> (irq_req && $stable(vec_idx))); // R8

  AST_REEVAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !held_live && (win_pri <= mask_q)) |=> !irq_req); // R9

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> !irq_req); // R10

  AST_ACK_RAISES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (mask_q == $past(held_pri))); // R10

  AST_EOI_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_take |=> (mask_q == $past(stk_top))); // R11

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && stk_full) |=> $stable(mask_q)); // R12

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && stk_empty && !ack_wr) |=> $stable(mask_q)); // R12

  AST_EOI_NOT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_take && eoi_take)); // R11
endmodule

bind prio_vec_intc pvi_checker #(.NSRC(NSRC), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .vec_idx   (vec_idx),
  .held_live (held_live),
  .ack_wr    (ack_wr),
  .eoi_wr    (eoi_wr),
  .ack_take  (ack_take),
  .eoi_take  (eoi_take),
  .stk_full  (stk_full),
  .stk_empty (stk_empty),
  .held_pri  (held_pri),
  .stk_top   (stk_top),
  .mask_q    (mask_q),
  .win_pri   (win_pri)
);

// File: tb/prio_vec_intc_tb.sv
`timescale 1ns/1ps
module prio_vec_intc_tb;
  localparam int NP = 12;
  localparam int NS = 4;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] irq_src;
  logic          reg_we;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          irq_req;
  logic [3:0]    vec_idx;
  logic [31:0]   vec_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  prio_vec_intc #(.N_PERIPH(NP), .N_SOFT(NS), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .vec_idx(vec_idx), .vec_addr(vec_addr)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = 32'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_addr = AW'(a);
    #1 v = reg_rdata;
  endtask

  task automatic set_irq(input int src, input logic val);
    @(negedge clk);
    irq_src[src-NS] = val;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_src = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    check("R1 req", 32'(irq_req), 0);
    check("R1 idx", 32'(vec_idx), 0);
    check("R1 addr", vec_addr, 0);
    rd(0, v);       check("R1 mask", v, 0);
    rd(256 + 5, v); check("R1 pri", v, 0);
    rd(4, v);       check("R1 sw", v, 0);
    rd(1, v);       check("R1 vbase", v, 0);
  endtask

  task automatic t_prio_rw();
    logic [31:0] v;
    do_reset();
    wr(256 + 5, 'hA);  rd(256 + 5, v); check("R2 pri rw", v, 'hA);
    wr(256 + 5, 'h3C); rd(256 + 5, v); check("R2 pri width", v, 'hC);
  endtask

  task automatic t_pri0();
    do_reset();
    set_irq(6, 1'b1); step(2);
    check("R3 periph pri0", 32'(irq_req), 0);
    wr(4, 'h1); step(2);
    check("R3 soft pri0", 32'(irq_req), 0);
  endtask

  task automatic t_mask();
    do_reset();
    wr(256 + 5, 10);
    wr(0, 10);
    set_irq(5, 1'b1); step(2);
    check("R4 equal blocked", 32'(irq_req), 0);
    wr(0, 9); step(1);
    check("R4 above mask req", 32'(irq_req), 1);
    check("R4 above mask idx", 32'(vec_idx), 5);
    set_irq(5, 1'b0); step(1);
    check("R9 source gone", 32'(irq_req), 0);
  endtask

  task automatic t_arb();
    do_reset();
    wr(256 + 4, 7); wr(256 + 8, 7); wr(256 + 9, 12); wr(256 + 1, 7);
    wr(0, 15);
    set_irq(4, 1'b1); set_irq(8, 1'b1);
    wr(0, 0); step(1);
    check("R5 tie lower number", 32'(vec_idx), 4);
    wr(0, 15); step(1);
    wr(4, 'h2); wr(0, 0); step(1);
    check("R5 soft before periph", 32'(vec_idx), 1);
    wr(0, 15); step(1);
    wr(5, 'h2); set_irq(9, 1'b1);
    wr(0, 0); step(1);
    check("R5 higher pri wins", 32'(vec_idx), 9);
    check("R5 req", 32'(irq_req), 1);
  endtask

  task automatic t_vec();
    logic [31:0] v;
    do_reset();
    wr(256 + 9, 12);
    set_irq(9, 1'b1); step(2);
    wr(1, 'h1000_0007);
    check("R6 vector address", vec_addr, 'h1000_0090);
    rd(1, v); check("R6 base low bits", v, 'h1000_0000);
  endtask

  task automatic t_soft();
    logic [31:0] v;
    do_reset();
    wr(4, 'h5); rd(4, v); check("R7 set", v, 'h5);
    wr(5, 'h1); rd(4, v); check("R7 clear", v, 'h4);
    wr(256 + 2, 3); step(1);
    check("R7 soft request idx", 32'(vec_idx), 2);
    check("R7 soft request req", 32'(irq_req), 1);
    wr(5, 'h4); step(1);
    check("R7 soft cleared", 32'(irq_req), 0);
  endtask

  task automatic t_hold();
    do_reset();
    wr(256 + 8, 7); wr(256 + 9, 12);
    set_irq(8, 1'b1); step(2);
    check("R8 first idx", 32'(vec_idx), 8);
    set_irq(9, 1'b1); step(2);
    check("R8 idx held", 32'(vec_idx), 8);
    check("R8 req held", 32'(irq_req), 1);
    set_irq(8, 1'b0); step(1);
    check("R9 switch idx", 32'(vec_idx), 9);
    check("R9 switch req", 32'(irq_req), 1);
    wr(0, 12); step(1);
    check("R9 mask raised", 32'(irq_req), 0);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    do_reset();
    wr(256 + 8, 7); wr(256 + 9, 12);
    wr(2, 0); rd(0, v); check("R10 ack idle ignored", v, 0);
    wr(3, 0); rd(0, v); check("R12 eoi empty ignored", v, 0);
    set_irq(8, 1'b1); step(2);
    rd(2, v); check("R10 ack read idx", v, 8);
    wr(2, 0);
    check("R10 req drops", 32'(irq_req), 0);
    rd(0, v); check("R10 mask raised", v, 7);
    set_irq(9, 1'b1); step(2);
    check("R10 preempt idx", 32'(vec_idx), 9);
    wr(2, 0); rd(0, v); check("R10 nested mask", v, 12);
    wr(3, 0); rd(0, v); check("R11 pop 1", v, 7);
    wr(3, 0); rd(0, v); check("R11 pop 2", v, 0);
  endtask

  task automatic t_full();
    logic [31:0] v;
    do_reset();
    wr(256 + 9, 12);
    set_irq(9, 1'b1);
    for (int i = 0; i < 16; i++) begin
      wr(0, i % 11); step(1);
      check("R12 fill req", 32'(irq_req), 1);
      wr(2, 0);
    end
    rd(0, v); check("R12 full mask", v, 12);
    wr(0, 3); step(1);
    wr(2, 0);
    rd(0, v); check("R12 ack when full ignored", v, 3);
    check("R12 req kept when full", 32'(irq_req), 1);
    for (int i = 15; i >= 0; i--) begin
      wr(3, 0); rd(0, v); check("R11 lifo order", v, 32'(i % 11));
    end
    wr(3, 0); rd(0, v); check("R12 extra eoi ignored", v, 0);
  endtask

  initial begin
    t_reset();
    t_prio_rw();
    t_pri0();
    t_mask();
    t_arb();
    t_vec();
    t_soft();
    t_hold();
    t_ack();
    t_full();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule